// File: doc/BRIEF.md
# Ultra DMA Burst CRC Checker

This block sits on the device side of a 16-bit Ultra DMA data path. It checks the interface CRC over every burst of one command. Each word strobe moves a 16-bit CRC register forward by one whole data word. The register is seeded with a fixed value at the start of every burst. When a burst ends, the CRC word sent by the host is compared bit for bit with the computed value.

A mismatch is held in a sticky flag for the rest of the command. Later bursts with a good CRC do not clear it. At command end the flag becomes the reported status, and the form of the report depends on the command class:
- a DMA transfer sets error bits;
- a request-sense packet command gets a check flag and an aborted-command key;
- any other packet command gets a check flag, a hardware-error key and a communication-CRC sense code.

On data-out commands the block passes received words to a data output until the command's word count is used up. Any words beyond that are still folded into the CRC but are not passed on.

Top module: `udma_crc_check`

## Requirements
- R1: The CRC uses the polynomial x^16 + x^12 + x^5 + 1 on one 16-bit word per strobe. The result equals shifting data bit 0 in first and bit 15 last, with the register's bit 15 as the feedback source. The register is seeded with 16'h4ABA at command start and again after every burst end.
- R2: At burst end, all 16 bits of `hostCrc` (bit n against CRC bit n) are compared with the computed CRC. A difference in any single bit, including bit 0 or bit 15, counts as a mismatch.
- R3: A mismatch stays latched through later bursts of the same command, whether those bursts are good or bad. Only command start clears it.
- R4: `cmdKind` encoding: 0 is DMA, 1 is request-sense, 2 and 3 are other packet commands. At command end of a DMA command with a latched mismatch, `errBits` becomes 8'h84 (bit 7 interface CRC, bit 2 abort), with `chkFlag` 0 and `senseKey` 0.
- R5: At command end of a request-sense command with a latched mismatch, `chkFlag` is 1 and `senseKey` is 4'hB. `ascCode` and `ascqCode` keep their earlier values.
- R6: At command end of any other packet command with a latched mismatch, `chkFlag` is 1, `senseKey` is 4'h4, `ascCode` is 8'h08 and `ascqCode` is 8'h03.
- R7: At command end with no mismatch, `errBits`, `chkFlag` and `senseKey` are 0. A clean other-packet command clears `ascCode` and `ascqCode` to 0. A request-sense or DMA command leaves them unchanged.
- R8: For a data-out command (`cmdWrite`=1), `outValid` pulses, with `outData` equal to the word, one clock after each strobe while words remain in the count loaded at command start. Surplus words, and every word of a data-in command, give no `outValid` but still enter the CRC.
- R9: `cmdStart` clears `errBits`, `chkFlag`, `senseKey` and the latched mismatch. `ascCode` and `ascqCode` persist across it.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Pulse: a new command begins |
| cmdKind | input | 2 | Command class, sampled at cmdStart |
| cmdWrite | input | 1 | 1 = data-out command, sampled at cmdStart |
| wordCount | input | COUNT_W | Words the command needs, sampled at cmdStart |
| wordStrobe | input | 1 | One data word is present on wordData |
| wordData | input | 16 | Data word on the bus |
| burstEnd | input | 1 | Pulse: burst ends, hostCrc is valid |
| hostCrc | input | 16 | CRC word sent by the host |
| cmdEnd | input | 1 | Pulse: command completes, status is produced |
| outValid | output | 1 | outData holds an accepted data-out word |
| outData | output | 16 | Accepted data word |
| errBits | output | 8 | Error register image |
| chkFlag | output | 1 | Packet command check condition |
| senseKey | output | 4 | Packet sense key |
| ascCode | output | 8 | Additional sense code |
| ascqCode | output | 8 | Additional sense code qualifier |

## Verification
The bench builds the block with its defaults: an 8-bit-wide use of the 16-bit word count and the 16'h4ABA seed. With these values, command lengths of zero through a few words, surplus words and empty bursts all fit into short runs. Commands of two bursts let a mismatch in the first burst be followed by a clean burst, and the reverse. Flipping bit 0 or bit 15 of the host CRC probes both ends of the comparison.

// File: rtl/udma_crc_pkg.sv
package udma_crc_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    CMD_DMA      = 2'd0,
    CMD_REQSENSE = 2'd1,
    CMD_PACKET   = 2'd2,
    CMD_PACKET2  = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic seedLoad;
    logic crcStep;
    logic countLoad;
  } dpCtrl_t;

  localparam logic [7:0] ERR_CRC_ABORT = 8'h84;
  localparam logic [3:0] KEY_ABORTED   = 4'hB;
  localparam logic [3:0] KEY_HW_ERROR  = 4'h4;
  localparam logic [7:0] ASC_LINK_CRC  = 8'h08;
  localparam logic [7:0] ASCQ_LINK_CRC = 8'h03;

  // Word-parallel step: same result as 16 serial shifts, data bit 0 first.
  function automatic logic [15:0] crcNext(input logic [15:0] c, input logic [15:0] d);
    logic [16:1] f;
    logic [15:0] n;
    f[1]  = d[0]  ^ c[15];
    f[2]  = d[1]  ^ c[14];
    f[3]  = d[2]  ^ c[13];
    f[4]  = d[3]  ^ c[12];
    f[5]  = d[4]  ^ c[11] ^ f[1];
    f[6]  = d[5]  ^ c[10] ^ f[2];
    f[7]  = d[6]  ^ c[9]  ^ f[3];
    f[8]  = d[7]  ^ c[8]  ^ f[4];
    f[9]  = d[8]  ^ c[7]  ^ f[5];
    f[10] = d[9]  ^ c[6]  ^ f[6];
    f[11] = d[10] ^ c[5]  ^ f[7];
    f[12] = d[11] ^ c[4]  ^ f[1] ^ f[8];
    f[13] = d[12] ^ c[3]  ^ f[2] ^ f[9];
    f[14] = d[13] ^ c[2]  ^ f[3] ^ f[10];
    f[15] = d[14] ^ c[1]  ^ f[4] ^ f[11];
    f[16] = d[15] ^ c[0]  ^ f[5] ^ f[12];
    n[0]  = f[16];
    n[1]  = f[15];
    n[2]  = f[14];
    n[3]  = f[13];
    n[4]  = f[12];
    n[5]  = f[11] ^ f[16];
    n[6]  = f[10] ^ f[15];
    n[7]  = f[9]  ^ f[14];
    n[8]  = f[8]  ^ f[13];
    n[9]  = f[7]  ^ f[12];
    n[10] = f[6]  ^ f[11];
    n[11] = f[5]  ^ f[10];
    n[12] = f[4]  ^ f[9]  ^ f[16];
    n[13] = f[3]  ^ f[8]  ^ f[15];
    n[14] = f[2]  ^ f[7]  ^ f[14];
    n[15] = f[1]  ^ f[6]  ^ f[13];
    return n;
  endfunction

endpackage

// File: rtl/udma_crc_datapath.sv
module udma_crc_datapath
  import udma_crc_pkg::*;
#(
  parameter int          COUNT_W = 16,
  parameter logic [15:0] SEED    = 16'h4ABA
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctl,
  input  logic               dirOut,
  input  logic [COUNT_W-1:0] wordCount,
  input  logic [WORD_W-1:0]  wordData,
  input  logic [WORD_W-1:0]  hostCrc,
  output logic               crcMatch,
  output logic               outValid,
  output logic [WORD_W-1:0]  outData
);

  logic [WORD_W-1:0]  crcReg;
  logic [COUNT_W-1:0] remaining;
  logic               hasRoom;

  assign hasRoom  = (remaining != '0);
  assign crcMatch = (hostCrc == crcReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg    <= SEED;
      remaining <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
    end else begin
      if (ctl.seedLoad)
        crcReg <= SEED;
      else if (ctl.crcStep)
        crcReg <= crcNext(crcReg, wordData);

      if (ctl.countLoad)
        remaining <= wordCount;
      else if (ctl.crcStep && hasRoom)
        remaining <= remaining - 1'b1;

      outValid <= ctl.crcStep && hasRoom && dirOut;
      if (ctl.crcStep && hasRoom && dirOut)
        outData <= wordData;
    end
  end

endmodule

// File: rtl/udma_crc_control.sv
module udma_crc_control
  import udma_crc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStart,
  input  logic [1:0] cmdKind,
  input  logic       cmdWrite,
  input  logic       wordStrobe,
  input  logic       burstEnd,
  input  logic       cmdEnd,
  input  logic       crcMatch,
  output dpCtrl_t    ctl,
  output logic       dirOut,
  output logic       stickyErr,
  output logic [7:0] errBits,
  output logic       chkFlag,
  output logic [3:0] senseKey,
  output logic [7:0] ascCode,
  output logic [7:0] ascqCode
);

  logic     active;
  cmdKind_e kindQ;

  always_comb begin
    ctl.countLoad = cmdStart;
    ctl.seedLoad  = cmdStart || (active && burstEnd);
    ctl.crcStep   = active && wordStrobe && !cmdStart && !burstEnd && !cmdEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      kindQ     <= CMD_DMA;
      dirOut    <= 1'b0;
      stickyErr <= 1'b0;
      errBits   <= '0;
      chkFlag   <= 1'b0;
      senseKey  <= '0;
      ascCode   <= '0;
      ascqCode  <= '0;
    end else if (cmdStart) begin
      active    <= 1'b1;
      kindQ     <= cmdKind_e'(cmdKind);
      dirOut    <= cmdWrite;
      stickyErr <= 1'b0;
      errBits   <= '0;
      chkFlag   <= 1'b0;
      senseKey  <= '0;
    end else if (active) begin
      if (burstEnd && !crcMatch)
        stickyErr <= 1'b1;
      if (cmdEnd) begin
        active <= 1'b0;
        unique case (kindQ)
          CMD_DMA: begin
            errBits <= stickyErr ? ERR_CRC_ABORT : 8'h00;
          end
          CMD_REQSENSE: begin
            chkFlag  <= stickyErr;
            senseKey <= stickyErr ? KEY_ABORTED : 4'h0;
          end
          CMD_PACKET, CMD_PACKET2: begin
            chkFlag  <= stickyErr;
            senseKey <= stickyErr ? KEY_HW_ERROR : 4'h0;
            ascCode  <= stickyErr ? ASC_LINK_CRC : 8'h00;
            ascqCode <= stickyErr ? ASCQ_LINK_CRC : 8'h00;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/udma_crc_check.sv
module udma_crc_check
  import udma_crc_pkg::*;
#(
  parameter int          COUNT_W = 16,
  parameter logic [15:0] SEED    = 16'h4ABA
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic [1:0]         cmdKind,
  input  logic               cmdWrite,
  input  logic [COUNT_W-1:0] wordCount,
  input  logic               wordStrobe,
  input  logic [15:0]        wordData,
  input  logic               burstEnd,
  input  logic [15:0]        hostCrc,
  input  logic               cmdEnd,
  output logic               outValid,
  output logic [15:0]        outData,
  output logic [7:0]         errBits,
  output logic               chkFlag,
  output logic [3:0]         senseKey,
  output logic [7:0]         ascCode,
  output logic [7:0]         ascqCode
);

  dpCtrl_t ctl;
  logic    dirOut;
  logic    crcMatch;
  logic    stickyErr;

  udma_crc_control u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdKind(cmdKind),
    .cmdWrite(cmdWrite), .wordStrobe(wordStrobe), .burstEnd(burstEnd),
    .cmdEnd(cmdEnd), .crcMatch(crcMatch), .ctl(ctl), .dirOut(dirOut),
    .stickyErr(stickyErr), .errBits(errBits), .chkFlag(chkFlag),
    .senseKey(senseKey), .ascCode(ascCode), .ascqCode(ascqCode)
  );

  udma_crc_datapath #(.COUNT_W(COUNT_W), .SEED(SEED)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dirOut(dirOut),
    .wordCount(wordCount), .wordData(wordData), .hostCrc(hostCrc),
    .crcMatch(crcMatch), .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/udma_crc_props.sv
module udma_crc_props (
  input logic       clk,
  input logic       rstN,
  input logic       cmdStart,
  input logic       wordStrobe,
  input logic       outValid,
  input logic [7:0] errBits,
  input logic       chkFlag,
  input logic [3:0] senseKey,
  input logic [7:0] ascCode,
  input logic [7:0] ascqCode,
  input logic       stickyErr
);

  // R4
  errbits_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errBits == 8'h00) || (errBits == 8'h84));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyErr && !cmdStart |=> stickyErr);

  // R8
  out_valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(wordStrobe));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> (errBits == 8'h00) && !chkFlag && (senseKey == 4'h0) && !stickyErr);

  // R5
  reqsense_keeps_sense_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkFlag && (senseKey == 4'hB) |-> $stable(ascCode) && $stable(ascqCode));

  // R6
  packet_sense_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    chkFlag && (senseKey == 4'h4) |-> (ascCode == 8'h08) && (ascqCode == 8'h03));

endmodule

bind udma_crc_check udma_crc_props u_props (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .wordStrobe(wordStrobe),
  .outValid(outValid), .errBits(errBits), .chkFlag(chkFlag),
  .senseKey(senseKey), .ascCode(ascCode), .ascqCode(ascqCode),
  .stickyErr(stickyErr)
);

// File: tb/udma_crc_check_bench.sv
module udma_crc_check_bench;

  localparam int COUNT_W = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               cmdStart = 1'b0;
  logic [1:0]         cmdKind = '0;
  logic               cmdWrite = 1'b0;
  logic [COUNT_W-1:0] wordCount = '0;
  logic               wordStrobe = 1'b0;
  logic [15:0]        wordData = '0;
  logic               burstEnd = 1'b0;
  logic [15:0]        hostCrc = '0;
  logic               cmdEnd = 1'b0;
  logic               outValid;
  logic [15:0]        outData;
  logic [7:0]         errBits;
  logic               chkFlag;
  logic [3:0]         senseKey;
  logic [7:0]         ascCode;
  logic [7:0]         ascqCode;

  int  tests = 0;
  int  fails = 0;
  int  seq = 0;
  bit  finished = 1'b0;
  logic [7:0] mAsc = 8'h00;
  logic [7:0] mAscq = 8'h00;

  always #4 clk = ~clk;

  udma_crc_check u_udma_crc_check (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdKind(cmdKind),
    .cmdWrite(cmdWrite), .wordCount(wordCount), .wordStrobe(wordStrobe),
    .wordData(wordData), .burstEnd(burstEnd), .hostCrc(hostCrc),
    .cmdEnd(cmdEnd), .outValid(outValid), .outData(outData),
    .errBits(errBits), .chkFlag(chkFlag), .senseKey(senseKey),
    .ascCode(ascCode), .ascqCode(ascqCode)
  );

  typedef struct packed {
    logic [1:0] kind;
    logic       wr;
    logic [7:0] count;
    logic [3:0] n1;
    logic [3:0] n2;
    logic       bad1;   // flips host CRC bit 0 of burst 1
    logic       bad2;   // flips host CRC bit 15 of burst 2
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 8'd5, 4'd3, 4'd4, 1'b0, 1'b0},
    '{2'd0, 1'b0, 8'd4, 4'd2, 4'd2, 1'b1, 1'b0},
    '{2'd2, 1'b1, 8'd3, 4'd3, 4'd0, 1'b0, 1'b1},
    '{2'd1, 1'b0, 8'd4, 4'd4, 4'd1, 1'b1, 1'b0},
    '{2'd3, 1'b0, 8'd2, 4'd1, 4'd1, 1'b0, 1'b0},
    '{2'd1, 1'b1, 8'd2, 4'd2, 4'd2, 1'b0, 1'b0},
    '{2'd1, 1'b0, 8'd1, 4'd1, 4'd1, 1'b0, 1'b1},
    '{2'd0, 1'b1, 8'd0, 4'd2, 4'd3, 1'b1, 1'b1}
  };

  function automatic logic [15:0] serialCrc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 16; i++) begin
      logic fb = d[i] ^ r[15];
      r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startCmd(input logic [1:0] k, input logic w, input int cnt);
    @(negedge clk);
    cmdStart = 1'b1; cmdKind = k; cmdWrite = w; wordCount = COUNT_W'(cnt);
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  // Sends n words, checks pass-through, returns model CRC.
  task automatic sendBurst(input int n, input logic w, inout int remain, output logic [15:0] crc);
    crc = 16'h4ABA;
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = 16'h1D0F ^ 16'(seq * 16'h3A7B);
      bit expV;
      seq++;
      wordStrobe = 1'b1; wordData = d;
      crc = serialCrc(crc, d);
      expV = w && (remain != 0);
      if (remain != 0) remain--;
      @(negedge clk);
      wordStrobe = 1'b0;
      check("R8", "outValid", outValid, expV);
      if (expV) check("R8", "outData", outData, d);
    end
  endtask

  task automatic endBurst(input logic [15:0] crc);
    burstEnd = 1'b1; hostCrc = crc;
    @(negedge clk);
    burstEnd = 1'b0;
  endtask

  task automatic endAndCheck(input logic [1:0] k, input bit err);
    logic [7:0] eErr = 8'h00;
    logic       eChk = 1'b0;
    logic [3:0] eKey = 4'h0;
    cmdEnd = 1'b1;
    @(negedge clk);
    cmdEnd = 1'b0;
    if (k == 2'd0) begin
      if (err) eErr = 8'h84;
    end else if (k == 2'd1) begin
      eChk = err; eKey = err ? 4'hB : 4'h0;
    end else begin
      eChk = err; eKey = err ? 4'h4 : 4'h0;
      mAsc = err ? 8'h08 : 8'h00; mAscq = err ? 8'h03 : 8'h00;
    end
    check(k == 2'd0 ? "R4" : "R7", "errBits", errBits, eErr);
    check(k == 2'd1 ? "R5" : "R6", "chkFlag", chkFlag, eChk);
    check(k == 2'd1 ? "R5" : "R6", "senseKey", senseKey, eKey);
    check(k == 2'd1 ? "R5" : "R6", "ascCode", ascCode, mAsc);
    check(k == 2'd1 ? "R5" : "R6", "ascqCode", ascqCode, mAscq);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] crc;
    int remain;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "outValid", outValid, 0);
    check("R10", "errBits", errBits, 0);
    check("R10", "chkFlag", chkFlag, 0);
    check("R10", "senseKey", senseKey, 0);
    check("R10", "ascCode", {ascCode, ascqCode}, 0);
    rstN = 1'b1;

    // R1, R2, R3: table of two-burst commands
    for (int v = 0; v < NVEC; v++) begin
      vec_t t = VECS[v];
      remain = int'(t.count);
      startCmd(t.kind, t.wr, int'(t.count));
      @(negedge clk);
      sendBurst(int'(t.n1), t.wr, remain, crc);
      endBurst(crc ^ (t.bad1 ? 16'h0001 : 16'h0000));
      sendBurst(int'(t.n2), t.wr, remain, crc);
      endBurst(crc ^ (t.bad2 ? 16'h8000 : 16'h0000));
      endAndCheck(t.kind, t.bad1 | t.bad2);
    end

    // R9: start clears error status, sense codes persist (last vector left 84h)
    startCmd(2'd2, 1'b0, 1);
    check("R9", "errBits", errBits, 0);
    check("R9", "chkFlag", chkFlag, 0);
    check("R9", "ascCode", ascCode, mAsc);
    // R1: empty burst compares against the seed itself
    endBurst(16'h4ABA);
    endAndCheck(2'd2, 1'b0);

    // R1: seed reloaded each burst; R3: bad burst then good burst stays failed
    remain = 0;
    startCmd(2'd0, 1'b0, 0);
    sendBurst(3, 1'b0, remain, crc);
    endBurst(crc ^ 16'h0100);
    sendBurst(3, 1'b0, remain, crc);
    endBurst(crc);
    endAndCheck(2'd0, 1'b1);

    // R6 then R5: packet error sets 08/03, request-sense error keeps them
    remain = 2;
    startCmd(2'd2, 1'b1, 2);
    sendBurst(2, 1'b1, remain, crc);
    endBurst(~crc);
    endAndCheck(2'd2, 1'b1);
    remain = 0;
    startCmd(2'd1, 1'b0, 0);
    sendBurst(1, 1'b0, remain, crc);
    endBurst(crc ^ 16'h0010);
    endAndCheck(2'd1, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule